// File: doc/BRIEF.md
# Single-Bit Table-Driven Sequencer Core

This core is a bit-serial controller without a program counter and without any arithmetic. Every instruction is four bytes in an external synchronous ROM. The first byte selects one bit of a 64-entry input bus to test, or one bit of a 64-entry output latch bank to set or clear. The second byte supplies the upper part of the next instruction index. The third and fourth bytes are two alternative lower parts. The tested bit picks between them, so every instruction is also a two-way branch. A program is therefore a state machine written out as a table. Two of the output latches can be read back as inputs, which gives the program two bits of scratch storage.

The core steps through four phases per instruction and issues one ROM read in each phase. The ROM returns data one cycle after the address. The reset input passes through a synchroniser. While that synchronised reset is high, the core holds the ROM address at zero and clears every latch, so execution always begins at instruction 0.

Top module: `onebit_core`

## Requirements
- R1: The ROM byte address is `{index, offset}`, where the two low bits are the offset. The phases run 0, 1, 2, 3 and repeat. Phase 0 presents offset 0 (I/O control byte), phase 1 presents offset 1 (page byte) and phase 3 presents offset 3. The instruction index changes only at the edge that ends phase 3.
- R2: The control byte uses bit 7 as the level to write, bit 6 as the direction (1 = write an output latch, 0 = test an input) and bits 5:0 as the I/O select. A write stores bit 7 into output latch `select`.
- R3: On a test (bit 6 = 0), bit 7 of the control byte has no effect on any output latch.
- R4: The next index is the 16-bit value `{page, successor}`, truncated to the low IDX_W bits.
- R5: In phase 2 the address offset is 2 (LOW successor) when the tested bit is 0 and 3 (HIGH successor) when it is 1. The byte fetched at that address becomes the successor.
- R6: On a write instruction, the tested bit is taken as 1, so the HIGH successor is used.
- R7: A write to select 0 changes no output latch.
- R8: Testing select 0 always yields 0 and testing select 1 always yields 1, whatever `in_bits[0]` and `in_bits[1]` carry.
- R9: Testing select 2 or 3 yields the current value of output latch 2 or 3, not the input pin.
- R10: Output latches change only at the edge that ends phase 3.
- R11: Reset passes through two flip-flops. From the third rising edge after `rst` is seen high, `rom_addr` and `out_bits` are zero. After release, execution starts at instruction 0, phase 0.
- R12: The tested input is sampled once, at the edge that ends phase 1. Later changes during the same instruction do not alter the chosen successor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset, asynchronous to clk, synchronised inside |
| rom_addr | output | IDX_W+2 | Byte address to the synchronous program ROM |
| rom_data | input | 8 | ROM byte, valid one cycle after its address |
| in_bits | input | 64 | Testable input bits; entries 0 to 3 are not used |
| out_bits | output | 64 | Output latch bank; bit 0 is never written |

## Verification
The bench builds the core with IDX_W = 9. This keeps the bench ROM at 2048 bytes while leaving the page byte wider than the index, so the truncation in R4 is actually exercised: page 0x03 with successor 0x05 must land on instruction 261. A behavioural model steps through the same phases and is compared with `rom_addr` and `out_bits` on every clock. Random values on the tested input drive both branches of each conditional instruction. Directed sequences cover a mid-run reset and an input that changes after it has been sampled.

// File: rtl/onebit_pkg.sv
package onebit_pkg;
  localparam int IO_AW     = 6;
  localparam int IO_N      = 1 << IO_AW;
  localparam int MEMBIT_LO = 2;
  localparam int MEMBIT_HI = 3;
  localparam int FULL_W    = 16;

  typedef struct packed {
    logic             level;
    logic             write;
    logic [IO_AW-1:0] sel;
  } ioctl_t;

  // phase name = byte offset presented on the ROM address in that phase
  typedef enum logic [1:0] {
    PH_CTL    = 2'd0,
    PH_PAGE   = 2'd1,
    PH_SUCC   = 2'd2,
    PH_COMMIT = 2'd3
  } phase_e;
endpackage

// File: rtl/onebit_rst_sync.sv
module onebit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], rst_in};
  end

  assign rst_out = chain[STAGES-1];
endmodule

// File: rtl/onebit_seq.sv
module onebit_seq
  import onebit_pkg::*;
#(
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic             din,
  input  logic [7:0]       rom_data,
  output phase_e           ph,
  output logic [IDX_W+1:0] rom_addr
);
  logic [IDX_W-1:0]  idx;
  logic [7:0]        page;
  logic [FULL_W-1:0] nxt_full;

  assign nxt_full = {page, rom_data};

  always_ff @(posedge clk) begin
    if (rst_s) begin
      ph   <= PH_CTL;
      idx  <= '0;
      page <= '0;
    end else begin
      ph <= phase_e'(ph + 2'd1);
      if (ph == PH_SUCC)   page <= rom_data;
      if (ph == PH_COMMIT) idx  <= nxt_full[IDX_W-1:0];
    end
  end

  always_comb begin
    if (ph == PH_SUCC) rom_addr = {idx, 1'b1, din};
    else               rom_addr = {idx, ph};
  end

  generate
    if (IDX_W < FULL_W) begin : g_trunc
      logic high_unused;
      assign high_unused = ^nxt_full[FULL_W-1:IDX_W];
    end
  endgenerate

  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst_s)
    (ph != PH_COMMIT) |=> $stable(idx));
endmodule

// File: rtl/onebit_io.sv
module onebit_io
  import onebit_pkg::*;
(
  input  logic            clk,
  input  logic            rst_s,
  input  phase_e          ph,
  input  logic [7:0]      rom_data,
  input  logic [IO_N-1:0] in_bits,
  output logic            din,
  output logic [IO_N-1:0] out_bits
);
  ioctl_t          ctl;
  ioctl_t          cur;
  logic            din_q;
  logic [IO_N-1:0] out_q;
  logic [IO_N-1:0] rd_src;
  logic            pins_unused;

  assign cur         = ioctl_t'(rom_data);
  assign pins_unused = ^in_bits[MEMBIT_HI:0];

  generate
    for (genvar k = 0; k < IO_N; k++) begin : g_src
      if (k == 0) begin : g_zero
        assign rd_src[k] = 1'b0;
      end else if (k == 1) begin : g_one
        assign rd_src[k] = 1'b1;
      end else if (k >= MEMBIT_LO && k <= MEMBIT_HI) begin : g_mem
        assign rd_src[k] = out_q[k];
      end else begin : g_pin
        assign rd_src[k] = in_bits[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_s) begin
      ctl   <= '0;
      din_q <= 1'b0;
      out_q <= '0;
    end else begin
      if (ph == PH_PAGE) begin
        ctl   <= cur;
        din_q <= cur.write ? 1'b1 : rd_src[cur.sel];
      end
      if (ph == PH_COMMIT && ctl.write && ctl.sel != '0)
        out_q[ctl.sel] <= ctl.level;
    end
  end

  assign din      = din_q;
  assign out_bits = out_q;

  // R10
  out_only_commit_chk: assert property (@(posedge clk) disable iff (rst_s)
    (ph != PH_COMMIT) |=> $stable(out_q));
  // R7
  null_sink_chk: assert property (@(posedge clk) disable iff (rst_s)
    (ph == PH_COMMIT && ctl.write && ctl.sel == '0) |=> $stable(out_q));
  // R6
  wr_high_chk: assert property (@(posedge clk) disable iff (rst_s)
    (ph == PH_PAGE && rom_data[6]) |=> din_q);
  // R8
  const_rd_chk: assert property (@(posedge clk) disable iff (rst_s)
    (ph == PH_PAGE && !rom_data[6] && rom_data[5:1] == 5'd0) |=> (din_q == $past(rom_data[0])));
  // R9
  mem_rd_chk: assert property (@(posedge clk) disable iff (rst_s)
    (ph == PH_PAGE && rom_data[6:0] == 7'd2) |=> (din_q == $past(out_q[2])));
endmodule

// File: rtl/onebit_core.sv
module onebit_core
  import onebit_pkg::*;
#(
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W+1:0] rom_addr,
  input  logic [7:0]       rom_data,
  input  logic [IO_N-1:0]  in_bits,
  output logic [IO_N-1:0]  out_bits
);
  logic   rst_s;
  logic   din;
  phase_e ph;

  onebit_rst_sync #(.STAGES(2)) i_sync (
    .clk     (clk),
    .rst_in  (rst),
    .rst_out (rst_s)
  );

  onebit_seq #(.IDX_W(IDX_W)) i_seq (
    .clk      (clk),
    .rst_s    (rst_s),
    .din      (din),
    .rom_data (rom_data),
    .ph       (ph),
    .rom_addr (rom_addr)
  );

  onebit_io i_io (
    .clk      (clk),
    .rst_s    (rst_s),
    .ph       (ph),
    .rom_data (rom_data),
    .in_bits  (in_bits),
    .din      (din),
    .out_bits (out_bits)
  );

  // R11
  rst_hold_chk: assert property (@(posedge clk)
    rst_s |=> (rom_addr == '0 && out_bits == '0));
endmodule

// File: tb/test_onebit_core.sv
module test_onebit_core;
  localparam int IDX_W = 9;
  localparam int AW    = IDX_W + 2;
  localparam int NI    = 1 << IDX_W;
  localparam int NB    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data = 8'h00;
  logic [63:0]   in_bits = '0;
  logic [63:0]   out_bits;
  logic [7:0]    rom [NB];

  int nvec = 0;
  int nbad = 0;
  bit rnd_on = 1'b0;
  bit seen261 = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) rom_data <= rom[rom_addr];

  onebit_core #(.IDX_W(IDX_W)) i_onebit_core (
    .clk      (clk),
    .rst      (rst),
    .rom_addr (rom_addr),
    .rom_data (rom_data),
    .in_bits  (in_bits),
    .out_bits (out_bits)
  );

  // behavioural reference
  int        m_ph = 0;
  int        m_idx = 0;
  bit        m_din = 1'b0;
  bit [63:0] m_out = '0;
  bit        m_r1 = 1'b0;
  bit        m_r2 = 1'b0;
  bit        m_valid = 1'b0;

  function automatic bit rdv(int a);
    if (a == 0) return 1'b0;
    if (a == 1) return 1'b1;
    if (a == 2 || a == 3) return m_out[a];
    return in_bits[a];
  endfunction

  always @(posedge clk) begin
    bit rs;
    int c, pg, sc;
    rs   = m_r2;
    m_r2 = m_r1;
    m_r1 = rst;
    if (rs) begin
      m_ph = 0; m_idx = 0; m_din = 1'b0; m_out = '0; m_valid = 1'b1;
    end else begin
      c = rom[m_idx*4];
      if (m_ph == 1) m_din = c[6] ? 1'b1 : rdv(c[5:0]);
      if (m_ph == 3) begin
        pg = rom[m_idx*4 + 1];
        sc = rom[m_idx*4 + 2 + int'(m_din)];
        if (c[6] && c[5:0] != 0) m_out[c[5:0]] = c[7];
        m_idx = (pg * 256 + sc) % NI;
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int ea;
    if (rom_addr == AW'(261*4)) seen261 = 1'b1;
    if (m_valid) begin
      ea = m_idx*4 + ((m_ph == 2) ? 2 + int'(m_din) : m_ph);
      chk((m_r2 || m_r1) ? "R11 address" : (m_ph == 2 ? "R5 address" : "R1 address"),
          64'(rom_addr), 64'(ea));
      chk("R10 latches", out_bits, m_out);
    end
  end

  always @(negedge clk) begin
    if (rnd_on) begin
      in_bits = {$urandom(), $urandom()};
      in_bits[3:0] = 4'b0001;
    end
  end

  task automatic put(int i, logic [7:0] c, logic [7:0] p, logic [7:0] lo, logic [7:0] hi);
    rom[i*4] = c; rom[i*4+1] = p; rom[i*4+2] = lo; rom[i*4+3] = hi;
  endtask

  task automatic clear_rom();
    for (int k = 0; k < NB; k++) rom[k] = 8'h00;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    logic [63:0] snap;
    clear_rom();
    put(0,   8'hC5, 8'h00, 8'h40, 8'd1);
    put(1,   8'h87, 8'h00, 8'd2,  8'd3);
    put(2,   8'hC9, 8'h00, 8'h40, 8'd4);
    put(3,   8'hCA, 8'h00, 8'h40, 8'd4);
    put(4,   8'hC0, 8'h03, 8'h40, 8'd5);
    put(261, 8'hC2, 8'h01, 8'h40, 8'd6);
    put(262, 8'h02, 8'h00, 8'd7,  8'd8);
    put(7,   8'hFF, 8'h00, 8'd7,  8'd7);
    put(8,   8'h01, 8'h00, 8'h40, 8'd9);
    put(9,   8'h00, 8'h00, 8'd12, 8'h40);
    put(12,  8'hCB, 8'h00, 8'h40, 8'd13);
    put(13,  8'h87, 8'h00, 8'd14, 8'd15);
    put(14,  8'hCC, 8'h00, 8'h40, 8'd16);
    put(15,  8'hCD, 8'h00, 8'h40, 8'd16);
    put(16,  8'h45, 8'h00, 8'h40, 8'd17);
    put(17,  8'h42, 8'h00, 8'h40, 8'd18);
    put(18,  8'h02, 8'h00, 8'd19, 8'd20);
    put(19,  8'hCE, 8'h00, 8'h40, 8'd21);
    put(20,  8'hCF, 8'h00, 8'h40, 8'd21);
    put(21,  8'h01, 8'h00, 8'h40, 8'd21);
    put(64,  8'hFF, 8'h00, 8'h40, 8'h40);

    cyc(5);
    chk("R11 reset address", 64'(rom_addr), 64'd0);
    chk("R11 reset latches", out_bits, 64'd0);
    rnd_on = 1'b1;
    rst = 1'b0;
    cyc(300);
    rnd_on = 1'b0;

    chk("R4 truncated page reached 261", 64'(seen261), 64'd1);
    chk("R7 null sink", 64'(out_bits[0]), 64'd0);
    chk("R6 write takes high", 64'(out_bits[63]), 64'd0);
    chk("R5 one branch of 9/10", 64'(out_bits[9] ^ out_bits[10]), 64'd1);
    chk("R5 one branch of 12/13", 64'(out_bits[12] ^ out_bits[13]), 64'd1);
    chk("R8 constants", 64'(out_bits[11]), 64'd1);
    chk("R9 readback low branch", 64'({out_bits[15], out_bits[14]}), 64'd1);
    chk("R9 mem bit cleared", 64'(out_bits[2]), 64'd0);
    chk("R3 read level ignored", 64'(out_bits[7]), 64'd0);
    chk("R2 level 0 write", 64'(out_bits[5]), 64'd0);

    snap = out_bits;
    rst = 1'b1;
    cyc(2);
    chk("R11 two-stage latency", out_bits, snap);
    cyc(1);
    chk("R11 cleared", out_bits, 64'd0);

    clear_rom();
    put(0, 8'h07, 8'h00, 8'd1, 8'd2);
    put(1, 8'hD4, 8'h00, 8'd1, 8'd1);
    put(2, 8'hD5, 8'h00, 8'd2, 8'd2);
    in_bits = 64'h80;
    cyc(2);
    rst = 1'b0;
    for (int k = 0; k < 20 && rom_addr != AW'(1); k++) @(negedge clk);
    chk("R1 phase 1 offset", 64'(rom_addr), 64'd1);
    @(negedge clk);
    in_bits[7] = 1'b0;
    chk("R12 sampled high kept", 64'(rom_addr), 64'd3);
    cyc(20);
    chk("R12 high path taken", 64'(out_bits[21:20]), 64'd2);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    nbad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    finish_run();
  end
endmodule